// File: doc/BRIEF.md
# Nonvolatile Store and Recall Sequencer

This block sequences the transfers between a volatile SRAM array and the nonvolatile cells that shadow it. A store moves array contents into the nonvolatile cells as an erase phase followed by a program phase. A recall moves the saved contents back as an array-clear phase followed by a load phase. Each phase is timed by an internal cycle counter. Each transfer is split so that its first phase takes half of the transfer's cycle budget, rounded down, and its second phase takes the rest.

A digital supply-good input stands in for the analog comparator. At reset, and whenever supply-good is low, the block latches a pending hardware recall. When the supply is good again, the block runs that recall by itself, using its own cycle budget. While any transfer is running, or while a hardware recall is pending, the active-low busy output is held low and host reads and writes to the array are blocked. Completion is marked by a one-clock done pulse, and busy returns high in that same clock.

Top module: `nv_xfer_seq`

## Requirements
- R1: From reset until the power-up recall completes, busy_n is low. The power-up recall drives arr_clear for HWREC_CYC/2 cycles and then arr_load for HWREC_CYC-HWREC_CYC/2 cycles.
- R2: A clock edge that samples pwr_good low abandons any running transfer without a done pulse. After that edge busy_n is low, done is low and all four phase outputs are low, and they stay so while pwr_good stays low.
- R3: After pwr_good returns high, a hardware recall starts with no request. It uses the HWREC_CYC phase lengths.
- R4: A store_req sampled while the block is ready drives nv_erase for STORE_CYC/2 cycles and then nv_prog for STORE_CYC-STORE_CYC/2 cycles. busy_n is low for exactly STORE_CYC cycles.
- R5: A recall_req sampled while the block is ready drives arr_clear for RECALL_CYC/2 cycles and then arr_load for RECALL_CYC-RECALL_CYC/2 cycles. busy_n is low for exactly RECALL_CYC cycles.
- R6: No recall, software or hardware, ever asserts nv_erase or nv_prog.
- R7: arr_rd_en follows host_rd, and arr_wr_en follows host_wr, only while busy_n is high. Otherwise both are low.
- R8: A store or recall request that arrives while a transfer is running is dropped. Once that transfer completes, the block stays idle with busy_n high.
- R9: A pending hardware recall wins over any software request. When store_req and recall_req are sampled together, the store runs.
- R10: done is high for exactly one clock at the end of each completed transfer, and busy_n is high in that same clock.
- R11: At most one of nv_erase, nv_prog, arr_clear and arr_load is high at a time. None of them is high while busy_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_good | input | 1 | Supply above the switch threshold |
| store_req | input | 1 | Request a store (array to nonvolatile) |
| recall_req | input | 1 | Request a recall (nonvolatile to array) |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| arr_rd_en | output | 1 | Gated read enable to the array |
| arr_wr_en | output | 1 | Gated write enable to the array |
| busy_n | output | 1 | Active-low busy handshake |
| done | output | 1 | One-clock completion pulse |
| nv_erase | output | 1 | Store phase 1: erase nonvolatile cells |
| nv_prog | output | 1 | Store phase 2: program nonvolatile cells |
| arr_clear | output | 1 | Recall phase 1: clear the array |
| arr_load | output | 1 | Recall phase 2: load the array |

## Verification
A wrong state register or phase counter shows up directly as a phase strobe of the wrong length. It can also show up as a store strobe appearing during a recall, or as busy_n rising one cycle early or late. Each of these can be seen within a single transfer of a few cycles. A lost pending-recall flag shows up as busy_n going high right after supply recovery instead of a clear/load pair. A request that leaks through while the block is busy shows up as a second, unrequested transfer in the idle cycles after done.

// File: rtl/nvs_pkg.sv
package nvs_pkg;

    typedef enum logic [2:0] {
        NVS_IDLE  = 3'd0,
        NVS_ERASE = 3'd1,
        NVS_PROG  = 3'd2,
        NVS_CLEAR = 3'd3,
        NVS_LOAD  = 3'd4
    } nvs_state_e;

    typedef enum logic [1:0] {
        GO_NONE   = 2'd0,
        GO_HWREC  = 2'd1,
        GO_STORE  = 2'd2,
        GO_RECALL = 2'd3
    } nvs_go_e;

    typedef struct packed {
        nvs_state_e st;
        logic       hw;
        logic       done;
    } nvs_ctl_t;

    typedef struct packed {
        logic pgood;
        logic pend;
    } nvs_sup_t;

    function automatic int first_half(input int cyc);
        return cyc / 2;
    endfunction

    function automatic int second_half(input int cyc);
        return cyc - cyc / 2;
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nvs_supply_mon.sv
module nvs_supply_mon
    import nvs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic take_pend,
    output logic pgood_q_o,
    output logic pend_q_o
);

    nvs_sup_t sup_d, sup_q;

    always_comb begin
        sup_d       = sup_q;
        sup_d.pgood = pwr_good;
        if (!pwr_good) begin
            sup_d.pend = 1'b1;
        end else if (take_pend) begin
            sup_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sup_q <= '{pgood: 1'b0, pend: 1'b1};
        end else begin
            sup_q <= sup_d;
        end
    end

    assign pgood_q_o = sup_q.pgood;
    assign pend_q_o  = sup_q.pend;

endmodule

// File: rtl/nvs_arbiter.sv
module nvs_arbiter
    import nvs_pkg::*;
(
    input  logic    idle,
    input  logic    pgood,
    input  logic    pend,
    input  logic    store_req,
    input  logic    recall_req,
    output nvs_go_e go
);

    always_comb begin
        go = GO_NONE;
        if (idle && pgood) begin
            if (pend) begin
                go = GO_HWREC;
            end else if (store_req) begin
                go = GO_STORE;
            end else if (recall_req) begin
                go = GO_RECALL;
            end
        end
    end

endmodule

// File: rtl/nvs_phase_timer.sv
module nvs_phase_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [CW-1:0] lim,
    output logic          last
);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        last  = (cnt_q == lim - CW'(1));
        cnt_d = cnt_q + CW'(1);
        if (clr || last) begin
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/nv_xfer_seq.sv
module nv_xfer_seq
    import nvs_pkg::*;
#(
    parameter int STORE_CYC  = 16000,
    parameter int RECALL_CYC = 400,
    parameter int HWREC_CYC  = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_good,
    input  logic store_req,
    input  logic recall_req,
    input  logic host_rd,
    input  logic host_wr,
    output logic arr_rd_en,
    output logic arr_wr_en,
    output logic busy_n,
    output logic done,
    output logic nv_erase,
    output logic nv_prog,
    output logic arr_clear,
    output logic arr_load
);

    localparam int S1   = first_half(STORE_CYC);
    localparam int S2   = second_half(STORE_CYC);
    localparam int R1C  = first_half(RECALL_CYC);
    localparam int R2C  = second_half(RECALL_CYC);
    localparam int H1   = first_half(HWREC_CYC);
    localparam int H2   = second_half(HWREC_CYC);
    localparam int MAXH = max3(S2, R2C, H2);
    localparam int CW   = $clog2(MAXH + 1);

    nvs_ctl_t      ctl_d, ctl_q;
    nvs_go_e       go;
    logic          pgood_q, pend_q;
    logic          idle, last, tmr_clr;
    logic [CW-1:0] lim;

    assign idle    = (ctl_q.st == NVS_IDLE);
    assign tmr_clr = idle || !pwr_good;

    nvs_supply_mon u_sup (
        .clk       (clk),
        .rst_n     (rst_n),
        .pwr_good  (pwr_good),
        .take_pend (go == GO_HWREC),
        .pgood_q_o (pgood_q),
        .pend_q_o  (pend_q)
    );

    nvs_arbiter u_arb (
        .idle       (idle),
        .pgood      (pgood_q),
        .pend       (pend_q),
        .store_req  (store_req),
        .recall_req (recall_req),
        .go         (go)
    );

    nvs_phase_timer #(.CW(CW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .lim   (lim),
        .last  (last)
    );

    // phase length for the phase now running
    always_comb begin
        unique case (ctl_q.st)
            NVS_ERASE: lim = CW'(S1);
            NVS_PROG:  lim = CW'(S2);
            NVS_CLEAR: lim = ctl_q.hw ? CW'(H1) : CW'(R1C);
            NVS_LOAD:  lim = ctl_q.hw ? CW'(H2) : CW'(R2C);
            default:   lim = CW'(1);
        endcase
    end

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        unique case (ctl_q.st)
            NVS_IDLE: begin
                unique case (go)
                    GO_HWREC:  begin ctl_d.st = NVS_CLEAR; ctl_d.hw = 1'b1; end
                    GO_STORE:  begin ctl_d.st = NVS_ERASE; ctl_d.hw = 1'b0; end
                    GO_RECALL: begin ctl_d.st = NVS_CLEAR; ctl_d.hw = 1'b0; end
                    default:   ctl_d.st = NVS_IDLE;
                endcase
            end
            NVS_ERASE: if (last) ctl_d.st = NVS_PROG;
            NVS_CLEAR: if (last) ctl_d.st = NVS_LOAD;
            NVS_PROG, NVS_LOAD: begin
                if (last) begin
                    ctl_d.st   = NVS_IDLE;
                    ctl_d.done = 1'b1;
                end
            end
            default: ctl_d.st = NVS_IDLE;
        endcase
        if (!pwr_good) begin
            ctl_d.st   = NVS_IDLE;
            ctl_d.hw   = 1'b0;
            ctl_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: NVS_IDLE, hw: 1'b0, done: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign busy_n    = idle && pgood_q && !pend_q;
    assign done      = ctl_q.done;
    assign nv_erase  = (ctl_q.st == NVS_ERASE);
    assign nv_prog   = (ctl_q.st == NVS_PROG);
    assign arr_clear = (ctl_q.st == NVS_CLEAR);
    assign arr_load  = (ctl_q.st == NVS_LOAD);
    assign arr_rd_en = host_rd && busy_n;
    assign arr_wr_en = host_wr && busy_n;

endmodule

// File: rtl/nvs_chk.sv
module nvs_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic arr_rd_en,
    input logic arr_wr_en,
    input logic busy_n,
    input logic done,
    input logic nv_erase,
    input logic nv_prog,
    input logic arr_clear,
    input logic arr_load
);

    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy_n);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R11
    one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({nv_erase, nv_prog, arr_clear, arr_load}));

    // R11
    quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_n |-> !(nv_erase || nv_prog || arr_clear || arr_load));

    // R4
    prog_after_erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nv_prog) |-> $past(nv_erase));

    // R5
    load_after_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arr_load) |-> $past(arr_clear));

    // R2
    supply_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_good |=> (!busy_n && !done &&
                       !(nv_erase || nv_prog || arr_clear || arr_load)));

    // R7
    host_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_rd_en || arr_wr_en) |-> !(nv_erase || nv_prog || arr_clear || arr_load));

endmodule

bind nv_xfer_seq nvs_chk u_nvs_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_good  (pwr_good),
    .arr_rd_en (arr_rd_en),
    .arr_wr_en (arr_wr_en),
    .busy_n    (busy_n),
    .done      (done),
    .nv_erase  (nv_erase),
    .nv_prog   (nv_prog),
    .arr_clear (arr_clear),
    .arr_load  (arr_load)
);

// File: tb/nv_xfer_seq_test.sv
module nv_xfer_seq_test;

    localparam int SC = 6;
    localparam int RC = 5;
    localparam int HC = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b1;
    logic store_req = 1'b0;
    logic recall_req = 1'b0;
    logic host_rd = 1'b1;
    logic host_wr = 1'b1;
    logic arr_rd_en, arr_wr_en, busy_n, done;
    logic nv_erase, nv_prog, arr_clear, arr_load;

    int nchk = 0;
    int nerr = 0;
    bit finished = 0;

    int n_ers, n_prg, n_clr, n_lod, n_busy;
    bit got_done, busy_at_done, done_after, gate_bad, multi_bad;

    always #10 clk = ~clk;

    nv_xfer_seq #(.STORE_CYC(SC), .RECALL_CYC(RC), .HWREC_CYC(HC)) uut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
        .store_req(store_req), .recall_req(recall_req),
        .host_rd(host_rd), .host_wr(host_wr),
        .arr_rd_en(arr_rd_en), .arr_wr_en(arr_wr_en),
        .busy_n(busy_n), .done(done),
        .nv_erase(nv_erase), .nv_prog(nv_prog),
        .arr_clear(arr_clear), .arr_load(arr_load)
    );

    task automatic checkv(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wrap_up();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    function automatic int strobes();
        return $countones({nv_erase, nv_prog, arr_clear, arr_load});
    endfunction

    // sample every negedge until done; optionally pulse store_req at one step
    task automatic track(input int inject_at);
        n_ers = 0; n_prg = 0; n_clr = 0; n_lod = 0; n_busy = 0;
        got_done = 0; gate_bad = 0; multi_bad = 0;
        for (int i = 0; i < 100; i++) begin
            if (inject_at >= 0) store_req = (i == inject_at);
            if (done) begin
                got_done = 1;
                break;
            end
            if (!busy_n) n_busy++;
            if (nv_erase) n_ers++;
            if (nv_prog) n_prg++;
            if (arr_clear) n_clr++;
            if (arr_load) n_lod++;
            if (arr_rd_en !== busy_n || arr_wr_en !== busy_n) gate_bad = 1;
            if (strobes() > 1 || (busy_n && strobes() != 0)) multi_bad = 1;
            @(negedge clk);
        end
        busy_at_done = busy_n;
        store_req = 1'b0;
        @(negedge clk);
        done_after = done;
    endtask

    task automatic pulse_req(input bit s, input bit r);
        store_req = s;
        recall_req = r;
        @(negedge clk);
        store_req = 1'b0;
        recall_req = 1'b0;
    endtask

    task automatic common_end(input string tag);
        checkv({tag, " R10 done seen"}, got_done, 1);
        checkv({tag, " R10 busy_n high with done"}, busy_at_done, 1);
        checkv({tag, " R10 done one clock"}, done_after, 0);
        checkv({tag, " R7 host gating"}, gate_bad, 0);
        checkv({tag, " R11 single phase strobe"}, multi_bad, 0);
    endtask

    initial begin
        #(20 * 5000);
        nchk++;
        nerr++;
        $display("FAIL watchdog expired");
        wrap_up();
    end

    initial begin
        bit bad;
        repeat (3) @(negedge clk);
        // R1 reset state
        checkv("R1 reset busy_n", busy_n, 0);
        checkv("R1 reset done", done, 0);
        checkv("R1 reset strobes", strobes(), 0);
        checkv("R7 reset arr_rd_en", arr_rd_en, 0);
        rst_n = 1'b1;

        // R1 power-up hardware recall
        track(-1);
        checkv("R1 clear cycles", n_clr, HC / 2);
        checkv("R1 load cycles", n_lod, HC - HC / 2);
        checkv("R6 hw recall no erase/prog", n_ers + n_prg, 0);
        common_end("R1");

        // R4 store
        pulse_req(1, 0);
        track(-1);
        checkv("R4 erase cycles", n_ers, SC / 2);
        checkv("R4 program cycles", n_prg, SC - SC / 2);
        checkv("R4 busy cycles", n_busy, SC);
        checkv("R4 no recall phases", n_clr + n_lod, 0);
        common_end("R4");

        // R5 software recall
        pulse_req(0, 1);
        track(-1);
        checkv("R5 clear cycles", n_clr, RC / 2);
        checkv("R5 load cycles", n_lod, RC - RC / 2);
        checkv("R5 busy cycles", n_busy, RC);
        checkv("R6 sw recall no erase/prog", n_ers + n_prg, 0);
        common_end("R5");

        // R9 simultaneous requests: store wins
        pulse_req(1, 1);
        track(-1);
        checkv("R9 store wins erase", n_ers, SC / 2);
        checkv("R9 store wins prog", n_prg, SC - SC / 2);
        checkv("R9 no recall run", n_clr + n_lod, 0);
        common_end("R9");

        // R8 sweep: store request at every cycle of a recall is dropped
        for (int off = 0; off < RC; off++) begin
            pulse_req(0, 1);
            track(off);
            checkv("R8 recall unaffected clear", n_clr, RC / 2);
            checkv("R8 recall unaffected load", n_lod, RC - RC / 2);
            checkv("R8 no erase during recall", n_ers, 0);
            bad = 0;
            for (int k = 0; k < 3; k++) begin
                if (!busy_n || strobes() != 0 || done) bad = 1;
                @(negedge clk);
            end
            checkv("R8 idle after dropped request", bad, 0);
        end

        // R2 supply drop in the middle of a store
        pulse_req(1, 0);
        @(negedge clk);
        pwr_good = 1'b0;
        @(negedge clk);
        checkv("R2 busy_n low after drop", busy_n, 0);
        checkv("R2 strobes off after drop", strobes(), 0);
        checkv("R2 no done on abort", done, 0);
        store_req = 1'b1;
        recall_req = 1'b1;
        bad = 0;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            if (busy_n || strobes() != 0 || done || arr_rd_en) bad = 1;
        end
        recall_req = 1'b0;
        checkv("R2 requests ignored while supply low", bad, 0);

        // R3/R9 recovery with store held: hardware recall runs instead
        pwr_good = 1'b1;
        @(negedge clk);
        checkv("R3 busy_n low on recovery", busy_n, 0);
        @(negedge clk);
        store_req = 1'b0;
        track(-1);
        checkv("R3 hw clear cycles", n_clr, HC / 2);
        checkv("R3 hw load cycles", n_lod, HC - HC / 2);
        checkv("R9 pending recall beats store", n_ers + n_prg, 0);
        common_end("R3");

        // R3 supply drop while idle also replays a hardware recall
        @(negedge clk);
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        checkv("R2 idle drop busy_n", busy_n, 0);
        pwr_good = 1'b1;
        repeat (2) @(negedge clk);
        track(-1);
        checkv("R3 idle-drop clear cycles", n_clr, HC / 2);
        checkv("R3 idle-drop load cycles", n_lod, HC - HC / 2);
        common_end("R3 idle");

        // R8 after everything: block is quiet and ready
        repeat (2) @(negedge clk);
        checkv("R8 final busy_n", busy_n, 1);
        checkv("R7 final arr_wr_en", arr_wr_en, 1);
        wrap_up();
    end

endmodule